// File: doc/BRIEF.md
# Address Bus Master Tenure Controller

This block sits on the master side of a split-transaction address bus. It watches a pending-transaction flag from the core and decides the cycle in which the processor takes the shared address bus. It raises a bus request toward the external arbiter, checks each grant against the shared busy and retry lines, and tracks the address tenure until the acknowledge arrives. During a tenure it drives the shared busy line. When the tenure ends it actively drives that line negated for one cycle, then releases it.

The pins are modelled as active-high internal signals. A separate output enable stands in for high impedance on the shared busy line. A one-cycle start strobe tells the address path when to place address and attributes on the bus. The block takes a granted bus even when it has not requested it, which supports bus parking.

Top module: `abus_tenure_ctl`

## Requirements
- R1: While `rst_ni` is low and on the first sample after its release, `bus_req_o`, `abb_o`, `abb_oe_o` and `tenure_start_o` are all 0.
- R2: When the block holds no tenure, `grant_i`=1, `abb_in_i`=0, `retry_i`=0, `pend_i`=1 and `cancel_i`=0 at a clock edge, ownership begins at that edge: `abb_o`=1 and `abb_oe_o`=1 from the next cycle.
- R3: A grant seen while `abb_in_i`=1 or `retry_i`=1 is not accepted, and `abb_o` stays 0.
- R4: A qualified grant is accepted even when `bus_req_o` was 0 in that cycle (bus parking).
- R5: While the block owns the bus, `grant_i` is ignored. `abb_o` stays 1 until the cycle after an edge with `ack_i`=1.
- R6: A grant that is qualified for a single cycle is enough. Ownership persists after `grant_i` returns to 0 in the first cycle of ownership.
- R7: If `cancel_i`=1 in the cycle a qualified grant would be accepted, ownership is not taken.
- R8: In the cycle after `ack_i` is seen during ownership, `abb_o`=0 and `abb_oe_o`=1 for exactly one cycle. After that `abb_oe_o`=0 until the next accepted grant.
- R9: `bus_req_o` is registered. It is 1 in the cycle after an edge with `pend_i`=1, `cancel_i`=0 and no ownership held or taken. Otherwise it is 0, and in particular it is 0 in the first cycle of ownership.
- R10: `tenure_start_o` pulses for exactly one cycle, the first cycle of each ownership.
- R11: `ack_i` seen while the block is not the owner has no effect: `abb_o` and `abb_oe_o` stay 0.
- R12: A qualified grant seen in the release cycle (R8) is accepted. Ownership resumes in the following cycle with a new start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pend_i | input | 1 | Core has an address transaction waiting |
| cancel_i | input | 1 | Core withdraws the waiting transaction |
| grant_i | input | 1 | Arbiter grant |
| abb_in_i | input | 1 | Sampled shared address-bus-busy line |
| retry_i | input | 1 | Address retry line |
| ack_i | input | 1 | Address acknowledge |
| bus_req_o | output | 1 | Bus request to the arbiter |
| abb_o | output | 1 | Driven value of the shared busy line |
| abb_oe_o | output | 1 | Output enable of the busy line (0 = released) |
| tenure_start_o | output | 1 | One-cycle pulse on the first cycle of ownership |

## Verification
The grant path is exercised with a grant that arrives after the request is raised, and with a grant that arrives together with the pending flag and no prior request. The first shows normal arbitration and the second shows parking. Grants blocked by the busy line, by retry and by a same-cycle cancel confirm that each qualifier gates acceptance separately. A grant held through a tenure, a stray acknowledge while idle, and a grant landing in the release cycle show that the ownership window opens and closes at the right edges. A long random phase compares every output on every cycle against a behavioural model of the same rules.

// File: rtl/abt_pkg.sv
package abt_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_OWN  = 2'd1,
    TS_REL  = 2'd2
  } ten_state_e;
endpackage

// File: rtl/abt_grant_qual.sv
module abt_grant_qual (
  input  logic owner_i,
  input  logic pend_i,
  input  logic cancel_i,
  input  logic grant_i,
  input  logic abb_in_i,
  input  logic retry_i,
  output logic take_o
);
  logic window, qualified;
  // window opens in idle and in the release cycle after ack
  assign window    = ~owner_i;
  assign qualified = grant_i & ~abb_in_i & ~retry_i & window;
  assign take_o    = qualified & pend_i & ~cancel_i;
endmodule

// File: rtl/abt_tenure_fsm.sv
module abt_tenure_fsm
  import abt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic ack_i,
  output logic owner_o,
  output logic own_nxt_o,
  output logic abb_o,
  output logic abb_oe_o,
  output logic start_o
);
  ten_state_e state_q, state_d;
  logic       start_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_IDLE, TS_REL: state_d = take_i ? TS_OWN : TS_IDLE;
      TS_OWN:          state_d = ack_i ? TS_REL : TS_OWN;
      default:         state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TS_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= take_i;
    end
  end

  assign owner_o   = (state_q == TS_OWN);
  assign own_nxt_o = (state_d == TS_OWN);
  assign abb_o     = owner_o;
  assign abb_oe_o  = owner_o | (state_q == TS_REL);
  assign start_o   = start_q;
endmodule

// File: rtl/abt_req_gen.sv
module abt_req_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic cancel_i,
  input  logic own_nxt_i,
  output logic req_o
);
  logic req_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= pend_i & ~cancel_i & ~own_nxt_i;
  end
  assign req_o = req_q;
endmodule

// File: rtl/abus_tenure_ctl.sv
module abus_tenure_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic cancel_i,
  input  logic grant_i,
  input  logic abb_in_i,
  input  logic retry_i,
  input  logic ack_i,
  output logic bus_req_o,
  output logic abb_o,
  output logic abb_oe_o,
  output logic tenure_start_o
);
  logic owner, own_nxt, take;

  abt_grant_qual i_qual (
    .owner_i (owner),
    .pend_i  (pend_i),
    .cancel_i(cancel_i),
    .grant_i (grant_i),
    .abb_in_i(abb_in_i),
    .retry_i (retry_i),
    .take_o  (take)
  );

  abt_tenure_fsm i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .ack_i    (ack_i),
    .owner_o  (owner),
    .own_nxt_o(own_nxt),
    .abb_o    (abb_o),
    .abb_oe_o (abb_oe_o),
    .start_o  (tenure_start_o)
  );

  abt_req_gen i_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend_i),
    .cancel_i (cancel_i),
    .own_nxt_i(own_nxt),
    .req_o    (bus_req_o)
  );
endmodule

// File: rtl/abus_tenure_ctl_chk.sv
module abus_tenure_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pend_i,
  input logic cancel_i,
  input logic grant_i,
  input logic abb_in_i,
  input logic retry_i,
  input logic ack_i,
  input logic bus_req_o,
  input logic abb_o,
  input logic abb_oe_o,
  input logic tenure_start_o
);
  // R2 R3 R7
  start_qualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tenure_start_o |-> $past(grant_i & ~abb_in_i & ~retry_i & pend_i & ~cancel_i));
  // R10
  start_with_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tenure_start_o |-> abb_o);
  // R10
  rise_has_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abb_o) |-> tenure_start_o);
  // R2
  busy_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abb_o |-> abb_oe_o);
  // R5
  hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abb_o && !ack_i) |=> abb_o);
  // R8
  release_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abb_o && ack_i) |=> (!abb_o && abb_oe_o));
  // R8
  release_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abb_oe_o && !abb_o) |=> (!abb_oe_o || abb_o));
  // R9
  no_req_when_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abb_o |-> !bus_req_o);
  // R11
  idle_ack_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!abb_oe_o && ack_i && !grant_i) |=> !abb_oe_o);
endmodule

bind abus_tenure_ctl abus_tenure_ctl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend_i), .cancel_i(cancel_i),
  .grant_i(grant_i), .abb_in_i(abb_in_i), .retry_i(retry_i), .ack_i(ack_i),
  .bus_req_o(bus_req_o), .abb_o(abb_o), .abb_oe_o(abb_oe_o),
  .tenure_start_o(tenure_start_o)
);

// File: tb/test_abus_tenure_ctl.sv
`timescale 1ns/1ps
module test_abus_tenure_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pend = 0, cancel = 0, grant = 0, abb_in = 0, retry = 0, ack = 0;
  logic req, abb, abb_oe, start;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  abus_tenure_ctl i_abus_tenure_ctl (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .cancel_i(cancel),
    .grant_i(grant), .abb_in_i(abb_in), .retry_i(retry), .ack_i(ack),
    .bus_req_o(req), .abb_o(abb), .abb_oe_o(abb_oe), .tenure_start_o(start)
  );

  // behavioural reference
  int m_own = 0, m_rel = 0, m_req = 0, m_start = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own = 0; m_rel = 0; m_req = 0; m_start = 0;
    end else begin
      int taking, nxt_own, nxt_rel;
      taking  = (grant && !abb_in && !retry && m_own == 0 && pend && !cancel) ? 1 : 0;
      nxt_own = taking ? 1 : ((m_own == 1 && ack) ? 0 : m_own);
      nxt_rel = (m_own == 1 && ack) ? 1 : 0;
      m_req   = (pend && !cancel && nxt_own == 0) ? 1 : 0;
      m_start = taking;
      m_own   = nxt_own;
      m_rel   = nxt_rel;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R9 bus_req_o vs model", int'(req), m_req);
    chk("R5 abb_o vs model", int'(abb), m_own);
    chk("R8 abb_oe_o vs model", int'(abb_oe), (m_own | m_rel));
    chk("R10 tenure_start_o vs model", int'(start), m_start);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic quiet();
    pend = 0; cancel = 0; grant = 0; abb_in = 0; retry = 0; ack = 0;
  endtask

  task automatic end_tenure();
    quiet(); ack = 1; cyc();
    ack = 0; cyc();
    cyc();
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 req in reset", int'(req), 0);
    chk("R1 abb_oe in reset", int'(abb_oe), 0);
    rst_n = 1'b1;
    cyc();
    chk("R1 abb after reset", int'(abb), 0);
    chk("R1 start after reset", int'(start), 0);

    // normal request then grant
    pend = 1; cyc();
    chk("R9 req raised", int'(req), 1);
    grant = 1; cyc();
    chk("R2 owner", int'(abb), 1);
    chk("R10 start pulse", int'(start), 1);
    chk("R9 req drops on ownership", int'(req), 0);
    pend = 0; grant = 0; cyc();
    chk("R6 ownership holds after grant drops", int'(abb), 1);
    chk("R10 start single cycle", int'(start), 0);
    pend = 1; grant = 1;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R5 grant ignored in tenure", int'(start), 0);
    end
    quiet(); ack = 1; cyc();
    chk("R8 driven negated", int'(abb), 0);
    chk("R8 still enabled", int'(abb_oe), 1);
    ack = 0; cyc();
    chk("R8 released", int'(abb_oe), 0);
    cyc();
    chk("R8 stays released", int'(abb_oe), 0);

    // blocked grants
    pend = 1; grant = 1; abb_in = 1; cyc();
    chk("R3 busy line blocks", int'(abb), 0);
    abb_in = 0; retry = 1; cyc();
    chk("R3 retry blocks", int'(abb), 0);
    retry = 0; cyc();
    chk("R3 accepted once clear", int'(abb), 1);
    end_tenure();

    // parking: grant with pend, no prior request
    chk("R4 no request before", int'(req), 0);
    pend = 1; grant = 1; cyc();
    chk("R4 parked grant taken", int'(abb), 1);
    quiet(); ack = 1; cyc();
    chk("R12 release cycle", int'(abb_oe) & ~int'(abb), 1);
    ack = 0; pend = 1; grant = 1; cyc();
    chk("R12 retaken from release", int'(abb), 1);
    chk("R12 new start", int'(start), 1);
    end_tenure();

    // cancel
    pend = 1; cancel = 1; grant = 1; cyc();
    chk("R7 cancel blocks", int'(abb), 0);
    chk("R9 no req on cancel", int'(req), 0);
    quiet(); cyc();

    // stray ack
    ack = 1; cyc();
    chk("R11 stray ack", int'(abb_oe), 0);
    ack = 0; cyc();
    chk("R11 still idle", int'(abb), 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      pend   = ($urandom_range(0, 3) != 0);
      cancel = ($urandom_range(0, 7) == 0);
      grant  = ($urandom_range(0, 1) == 1);
      abb_in = ($urandom_range(0, 5) == 0);
      retry  = ($urandom_range(0, 7) == 0);
      ack    = ($urandom_range(0, 3) == 0);
      cyc();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule